// File: doc/BRIEF.md
# Cascadable Display Line Sampling Register

This block collects the gray-scale codes for one display line before they are latched and converted. Each clock delivers a 36-bit word holding six 6-bit dots, which is two RGB pixels. A start pulse arms the block. From that edge on, every rising clock edge stores the six dots into the next group of six slots of a 384-slot line buffer. One line therefore takes 64 capture edges.

Devices are chained. A direction input decides which of two bidirectional start pins accepts the start pulse, which one passes a pulse on to the next device, and from which end the buffer fills. When the last group has been stored, the block raises its outgoing start pin for one clock so that the next device begins capturing. Each half of the data word can be complemented on its way into the buffer, under its own control input.

Top module: `line_sampler`

## Requirements
- R1: After reset every slot of the line buffer reads 0, and the outgoing start pin is driven low.
- R2: The rising edge that samples the incoming start pin high stores the current data word as group 0. Each following edge stores the next group, up to group 63.
- R3: With `shift_right_i` high, `start_r_io` is the start input and `start_l_io` is the outgoing pin. Dot k (0..5) of group g is stored in slot 6g+k, so slot 0 fills first.
- R4: With `shift_right_i` low, `start_l_io` is the start input and `start_r_io` is the outgoing pin. Dot k of group g is stored in slot 383-(6g+k), so slot 383 fills first.
- R5: When `inv_lo_i` is high, dots 0..2 (data bits 17:0) are bitwise complemented before they are stored. Dots 3..5 are not affected.
- R6: When `inv_hi_i` is high, dots 3..5 (data bits 35:18) are bitwise complemented before they are stored. Dots 0..2 are not affected.
- R7: The outgoing start pin is high for exactly one clock, beginning at the edge that stores group 63. It is low at all other times.
- R8: The block never drives the pin that is currently the start input. That pin carries whatever level the upstream device drives.
- R9: A start pulse seen while a capture is in progress restarts the capture: that edge stores group 0, and the cascade pulse comes only after 64 further groups.
- R10: After group 63 the block is idle. Data words that arrive without a start pulse leave the buffer unchanged and raise no cascade pulse.
- R11: Dot k of the data word occupies bits 6k+5..6k, with bit 6k as its LSB. Slot s is presented on `samples_o` bits 6s+5..6s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_r_io | inout | 1 | Right start pin: start input when shifting right, cascade output otherwise |
| start_l_io | inout | 1 | Left start pin: cascade output when shifting right, start input otherwise |
| shift_right_i | input | 1 | 1 = fill from slot 0 upward, 0 = fill from slot 383 downward |
| inv_lo_i | input | 1 | Complement dots 0..2 at capture |
| inv_hi_i | input | 1 | Complement dots 3..5 at capture |
| data_i | input | 36 | Six 6-bit dots per clock |
| samples_o | output | 2304 | Line buffer, 384 slots of 6 bits |

## Verification
The assertions check the sequencing on every cycle. A start always resets the group count. Each busy edge advances it by exactly one. The last group is followed by a single-cycle pulse and the idle state, and an idle edge without a start leaves the buffer untouched. Slot 0 gets the correct low-port data with inversion applied. Only the bench scenarios can show the complete slot mapping in both directions, the high-port inversion, the pin roles and the absence of contention on the input pin, and a restart partway through a line followed by a full line of new data.

// File: rtl/line_sampler.sv
module line_sampler #(
  parameter int DOTS    = 384,
  parameter int BITS    = 6,
  parameter int PER_CLK = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  inout  wire                    start_r_io,
  inout  wire                    start_l_io,
  input  logic                   shift_right_i,
  input  logic                   inv_lo_i,
  input  logic                   inv_hi_i,
  input  logic [PER_CLK*BITS-1:0] data_i,
  output logic [DOTS*BITS-1:0]   samples_o
);
  localparam int W      = PER_CLK * BITS;
  localparam int HALF   = (PER_CLK / 2) * BITS;
  localparam int GROUPS = DOTS / PER_CLK;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int IW     = $clog2(DOTS);

  logic                       busy_q;
  logic                       pulse_q;
  logic [GW-1:0]              grp_q;
  logic [DOTS-1:0][BITS-1:0]  line_q;
  logic [PER_CLK-1:0][IW-1:0] idx;

  wire          start_in = shift_right_i ? start_r_io : start_l_io;
  wire          take     = start_in | busy_q;
  wire [GW-1:0] cur_grp  = start_in ? '0 : grp_q;
  wire          last     = take && (cur_grp == GW'(GROUPS - 1));
  wire [W-1:0]  word     = data_i ^ {{(W - HALF){inv_hi_i}}, {HALF{inv_lo_i}}};

  assign start_r_io = shift_right_i ? 1'bz : pulse_q;
  assign start_l_io = shift_right_i ? pulse_q : 1'bz;
  assign samples_o  = line_q;

  for (genvar k = 0; k < PER_CLK; k++) begin : g_slot
    wire [31:0] lin = 32'(cur_grp) * 32'(PER_CLK) + 32'(k);
    assign idx[k] = shift_right_i ? IW'(lin) : IW'(32'(DOTS - 1) - lin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      grp_q   <= '0;
      line_q  <= '0;
    end else begin
      pulse_q <= last;
      if (take) begin
        busy_q <= !last;
        grp_q  <= cur_grp + 1'b1;
        for (int k = 0; k < PER_CLK; k++)
          line_q[idx[k]] <= word[k*BITS +: BITS];
      end
    end
  end

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_in |=> busy_q && grp_q == GW'(1));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !start_in && grp_q != GW'(GROUPS - 1) |=> busy_q && grp_q == $past(grp_q) + 1'b1);

  p_last_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !start_in && grp_q == GW'(GROUPS - 1) |=> pulse_q && !busy_q);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start_in |=> $stable(line_q) && !pulse_q);

  p_slot0_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_in && shift_right_i |=> line_q[0] == ($past(data_i[BITS-1:0]) ^ {BITS{$past(inv_lo_i)}}));
endmodule

// File: tb/line_sampler_tb_top.sv
module line_sampler_tb_top;
  localparam int DOTS = 384, BITS = 6, PER = 6, GROUPS = DOTS / PER;

  logic clk = 0, rst_n = 0;
  logic shift_right = 1, inv_lo = 0, inv_hi = 0;
  logic [PER*BITS-1:0] data = '0;
  logic r_en = 1, r_val = 0, l_en = 0, l_val = 0;
  wire start_r, start_l;
  logic [DOTS*BITS-1:0] samples;
  logic [DOTS-1:0][BITS-1:0] exp_line = '0;
  int checks = 0, fails = 0;

  assign start_r = r_en ? r_val : 1'bz;
  assign start_l = l_en ? l_val : 1'bz;

  line_sampler dut_i (.clk(clk), .rst_n(rst_n), .start_r_io(start_r), .start_l_io(start_l),
    .shift_right_i(shift_right), .inv_lo_i(inv_lo), .inv_hi_i(inv_hi), .data_i(data),
    .samples_o(samples));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_line(string req);
    int bad = -1;
    for (int s = DOTS - 1; s >= 0; s--)
      if (samples[s*BITS +: BITS] !== exp_line[s]) bad = s;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s slot %0d actual=%0h expected=%0h", req, bad,
               samples[bad*BITS +: BITS], exp_line[bad]);
    end
  endtask

  function automatic logic [5:0] dotv(int seed, int g, int k);
    return 6'((seed + g * 7 + k * 13 + g * k) & 63);
  endfunction

  function automatic logic out_pin();
    return shift_right ? start_l : start_r;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_mode(logic right);
    shift_right = right; r_en = right; l_en = !right; r_val = 0; l_val = 0;
  endtask

  task automatic set_start(logic v);
    if (shift_right) r_val = v; else l_val = v;
  endtask

  task automatic feed(int seed, int g, logic st);
    set_start(st);
    for (int k = 0; k < PER; k++) begin
      data[k*BITS +: BITS] = dotv(seed, g, k);
      exp_line[shift_right ? g*PER + k : DOTS - 1 - (g*PER + k)] =
        dotv(seed, g, k) ^ {BITS{(k < PER/2) ? inv_lo : inv_hi}};
    end
    step();
  endtask

  task automatic run_line(int seed, string req);
    for (int g = 0; g < GROUPS; g++) begin
      if (g == 0) begin
        set_start(1'b1); #1;
        chk({"R8 input pin ", req}, 64'(shift_right ? start_r : start_l), 64'(1));
      end
      if (g == GROUPS - 1) chk({"R7 no early pulse ", req}, 64'(out_pin()), 64'(0));
      feed(seed, g, g == 0);
    end
    set_start(1'b0);
    chk({"R7 pulse high ", req}, 64'(out_pin()), 64'(1));
    chk({"R8 input pin idle ", req}, 64'(shift_right ? start_r : start_l), 64'(0));
    step();
    chk({"R7 pulse one cycle ", req}, 64'(out_pin()), 64'(0));
  endtask

  task automatic t_reset();
    chk_line("R1 buffer cleared");
    chk("R1 outgoing pin low", 64'(out_pin()), 64'(0));
  endtask

  task automatic t_right();
    set_mode(1); inv_lo = 0; inv_hi = 0;
    run_line(5, "R3");
    chk_line("R2 R3 right fill");
    chk("R11 slot1 bits", 64'(samples[11:6]), 64'(dotv(5, 0, 1)));
    chk("R11 slot5 bits", 64'(samples[35:30]), 64'(dotv(5, 0, 5)));
  endtask

  task automatic t_left();
    set_mode(0);
    run_line(9, "R4");
    chk_line("R4 left fill");
    chk("R4 slot383 is dot0", 64'(samples[DOTS*BITS-1 -: BITS]), 64'(dotv(9, 0, 0)));
  endtask

  task automatic t_inv_lo();
    set_mode(1); inv_lo = 1; inv_hi = 0;
    run_line(21, "R5");
    chk_line("R5 low port inverted");
    inv_lo = 0;
  endtask

  task automatic t_inv_hi();
    set_mode(0); inv_lo = 0; inv_hi = 1;
    run_line(33, "R6");
    chk_line("R6 high port inverted");
    inv_hi = 0;
  endtask

  task automatic t_restart();
    set_mode(1);
    for (int g = 0; g < 10; g++) feed(3, g, g == 0);
    chk("R9 no pulse mid line", 64'(out_pin()), 64'(0));
    run_line(11, "R9");
    chk_line("R9 restarted line");
  endtask

  task automatic t_idle();
    set_mode(1);
    set_start(1'b0);
    for (int g = 0; g < 12; g++) begin
      for (int k = 0; k < PER; k++) data[k*BITS +: BITS] = dotv(40, g, k);
      step();
      if (out_pin() !== 1'b0) chk("R10 no pulse when idle", 64'(out_pin()), 64'(0));
    end
    chk_line("R10 idle data ignored");
    chk("R10 outgoing pin low", 64'(out_pin()), 64'(0));
  endtask

  initial begin
    #100_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_right();
    t_idle();
    t_left();
    t_inv_lo();
    t_inv_hi();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule